// File: doc/BRIEF.md
# MESI Snooping Cache Cluster

This block is a set of identical direct-mapped write-back caches that share one snooping bus and a flat backing memory. Each cache serves one processor through a valid/ready request port and holds every line in one of four coherence states: Invalid, Shared, Exclusive or Modified. A miss becomes a bus read (shared copy wanted) or a bus read-for-ownership (sole copy wanted). All other caches watch each transaction in the cycle it is on the bus and adjust their own copies to match.

Only one transaction runs on the bus in a cycle. A fixed-priority picker grants the lowest-numbered cache that is asking. If another cache already holds the line, that cache supplies the data. When several caches hold it, the one with the lowest index is chosen. A dirty owner that supplies data also writes it to memory in the same cycle. When a dirty line must make room for a different address, it is first written back in a separate bus cycle. A clean line in the same position is simply dropped.

The transaction in flight is visible on the outputs, as is each cache's state for one probed address. The processor side sees only its handshake and its read data.

Top module: `mesi_cluster`

## Requirements
- R1: A read that misses issues a bus read (command code 1). The requester fills the line as Exclusive (state code 2) if no other cache holds a copy, and as Shared (state code 1) if `bus_shared` is high.
- R2: A write to a line held Exclusive completes in the same cycle with no bus transaction, and the line becomes Modified (state code 3).
- R3: A write to a line held Shared, or a write miss, issues a read-for-ownership (command code 2). After it, the requester holds the line Modified and every other cache holds it Invalid (state code 0).
- R4: A read that hits in Modified, Exclusive or Shared, and a write that hits in Modified, raise `cpu_ready` in the cycle of the request, use no bus cycle and leave the state unchanged. `cpu_ready` is never high without `cpu_valid`.
- R5: When another cache's bus read hits a line, that line becomes Shared. When it hits a Modified line, the owner's data is delivered to the requester and written to memory.
- R6: When one or more other caches hold the line, `bus_c2c` is high and `bus_supplier` is the lowest index among them. Memory supplies the data only when no other cache holds the line.
- R7: A miss that falls on a Modified line of a different address first produces a write-back cycle (command code 3). That cycle carries the victim's address and data, does not complete the request, and is followed by the fill. A clean victim is dropped with no write-back cycle.
- R8: Among caches requesting the bus in the same cycle, the lowest index is granted. A waiting cache keeps its request, and its lines still respond to the transactions of others.
- R9: For any address, at most one cache holds it Modified, and a Modified copy is the only valid copy.
- R10: After reset all lines are Invalid and the bus is idle (command code 0, `bus_shared` and `bus_c2c` low). Memory word `a` holds `a XOR 0x5A`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | N | Request valid, one bit per cache |
| cpu_write | input | N | Request is a write, one bit per cache |
| cpu_addr | input | N*AW | Request word address, AW bits per cache |
| cpu_wdata | input | N*DW | Write data, DW bits per cache |
| cpu_ready | output | N | Request completes this cycle |
| cpu_rdata | output | N*DW | Read data, valid with `cpu_ready` on a read |
| bus_active | output | 1 | A transaction is on the bus this cycle |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 read-for-ownership, 3 write-back |
| bus_src | output | IW | Index of the granted cache |
| bus_addr | output | AW | Address of the transaction |
| bus_shared | output | 1 | Wired-OR of other caches holding the line |
| bus_c2c | output | 1 | Data comes from another cache |
| bus_supplier | output | IW | Index of the supplying cache when `bus_c2c` is high |
| bus_data | output | DW | Data moved by the transaction |
| probe_addr | input | AW | Address whose state is reported |
| probe_state | output | N*2 | State of `probe_addr` in each cache |

## Verification
Bus outputs, `cpu_ready` and fill data are combinational and belong to the cycle of the grant. A state change made by a transaction or a silent write shows on `probe_state` one clock later, and a write to memory is seen by the next transaction that reads it. The reference model in the bench is evaluated at the falling edge, halfway between the edge that applied the inputs and the edge that commits the result. It compares that cycle's outputs, then advances its own state as the coming rising edge will. Scenario checks read the captured transaction and the probed states only after the request's completing edge has passed.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_RDX  = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_t;

    function automatic mesi_t fill_state(logic others_hold);
        return others_hold ? ST_S : ST_E;
    endfunction

    function automatic logic may_write_silently(mesi_t st);
        return (st == ST_E) || (st == ST_M);
    endfunction

endpackage

// File: rtl/mesi_low_pick.sv
module mesi_low_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mesi_flat_mem.sv
module mesi_flat_mem #(
    parameter int          AW   = 6,
    parameter int          DW   = 8,
    parameter int unsigned SEED = 'h5A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < WORDS; a++) mem_q[a] <= DW'(a) ^ DW'(SEED);
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int N    = 3,
    parameter int ID   = 0,
    parameter int AW   = 6,
    parameter int DW   = 8,
    parameter int SETS = 4,
    parameter int IW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          breq,
    output bus_cmd_t      breq_cmd,
    output logic [AW-1:0] breq_addr,
    output logic [DW-1:0] breq_data,
    input  logic          gnt,
    input  logic          bus_active,
    input  bus_cmd_t      bus_cmd,
    input  logic [AW-1:0] bus_addr,
    input  logic [IW-1:0] bus_src,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_shared,
    output logic          snp_hit,
    output logic          snp_dirty,
    output logic [DW-1:0] snp_data,
    input  logic [AW-1:0] probe_addr,
    output mesi_t         probe_st
);
    localparam int IXW = $clog2(SETS);
    localparam int TW  = AW - IXW;

    mesi_t         st_q  [SETS];
    logic [TW-1:0] tag_q [SETS];
    logic [DW-1:0] dat_q [SETS];

    logic [IXW-1:0] cidx, bidx, pidx;
    logic [TW-1:0]  ctag, btag, ptag;
    mesi_t          cur;
    logic           hit, need, victim, other, blocked, local_done;

    assign cidx = cpu_addr[IXW-1:0];
    assign ctag = cpu_addr[AW-1:IXW];
    assign bidx = bus_addr[IXW-1:0];
    assign btag = bus_addr[AW-1:IXW];
    assign pidx = probe_addr[IXW-1:0];
    assign ptag = probe_addr[AW-1:IXW];

    // Local lookup
    assign cur    = st_q[cidx];
    assign hit    = (cur != ST_I) && (tag_q[cidx] == ctag);
    assign need   = cpu_valid && (cpu_write ? !(hit && may_write_silently(cur)) : !hit);
    assign victim = !hit && (cur == ST_M);

    assign breq      = need;
    assign breq_cmd  = victim ? CMD_WB : (cpu_write ? CMD_RDX : CMD_RD);
    assign breq_addr = victim ? {tag_q[cidx], cidx} : cpu_addr;
    assign breq_data = dat_q[cidx];

    // Snoop side
    assign other     = bus_active && (bus_src != IW'(ID));
    assign snp_hit   = other && (bus_cmd == CMD_RD || bus_cmd == CMD_RDX)
                       && (st_q[bidx] != ST_I) && (tag_q[bidx] == btag);
    assign snp_dirty = snp_hit && (st_q[bidx] == ST_M);
    assign snp_data  = dat_q[bidx];

    // A foreign transaction on the same set holds back a local hit
    assign blocked    = other && (bidx == cidx);
    assign local_done = cpu_valid && !need && !blocked;
    assign cpu_ready  = local_done || (gnt && breq_cmd != CMD_WB);
    assign cpu_rdata  = gnt ? bus_data : dat_q[cidx];

    assign probe_st = ((st_q[pidx] != ST_I) && (tag_q[pidx] == ptag)) ? st_q[pidx] : ST_I;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                st_q[s]  <= ST_I;
                tag_q[s] <= '0;
                dat_q[s] <= '0;
            end
        end else begin
            if (snp_hit) st_q[bidx] <= (bus_cmd == CMD_RD) ? ST_S : ST_I;
            if (gnt) begin
                unique case (breq_cmd)
                    CMD_WB:  st_q[cidx] <= ST_I;
                    CMD_RD: begin
                        st_q[cidx]  <= fill_state(bus_shared);
                        tag_q[cidx] <= ctag;
                        dat_q[cidx] <= bus_data;
                    end
                    CMD_RDX: begin
                        st_q[cidx]  <= ST_M;
                        tag_q[cidx] <= ctag;
                        dat_q[cidx] <= cpu_wdata;
                    end
                    default: ;
                endcase
            end else if (local_done && cpu_write) begin
                st_q[cidx]  <= ST_M;
                dat_q[cidx] <= cpu_wdata;
            end
        end
    end
endmodule

// File: rtl/mesi_cluster.sv
module mesi_cluster
    import mesi_pkg::*;
#(
    parameter int          N        = 3,
    parameter int          AW       = 6,
    parameter int          DW       = 8,
    parameter int          SETS     = 4,
    parameter int unsigned MEM_SEED = 'h5A,
    localparam int         IW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    cpu_valid,
    input  logic [N-1:0]    cpu_write,
    input  logic [N*AW-1:0] cpu_addr,
    input  logic [N*DW-1:0] cpu_wdata,
    output logic [N-1:0]    cpu_ready,
    output logic [N*DW-1:0] cpu_rdata,
    output logic            bus_active,
    output logic [1:0]      bus_cmd,
    output logic [IW-1:0]   bus_src,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_shared,
    output logic            bus_c2c,
    output logic [IW-1:0]   bus_supplier,
    output logic [DW-1:0]   bus_data,
    input  logic [AW-1:0]   probe_addr,
    output logic [N*2-1:0]  probe_state
);
    logic [N-1:0]  breq, gnt, snp_hit, snp_dirty;
    bus_cmd_t      rq_cmd   [N];
    logic [AW-1:0] rq_addr  [N];
    logic [DW-1:0] rq_data  [N];
    logic [DW-1:0] snp_data [N];
    mesi_t         pst      [N];

    logic          act, any_sup, mem_we;
    logic [IW-1:0] gidx, sidx;
    bus_cmd_t      cmd_w;
    logic [AW-1:0] addr_w;
    logic [DW-1:0] data_w, mem_rdata;

    mesi_low_pick #(.N(N), .IW(IW)) u_arb (.req(breq),    .any(act),     .idx(gidx));
    mesi_low_pick #(.N(N), .IW(IW)) u_sup (.req(snp_hit), .any(any_sup), .idx(sidx));

    assign cmd_w  = act ? rq_cmd[gidx] : CMD_IDLE;
    assign addr_w = act ? rq_addr[gidx] : '0;
    assign data_w = (cmd_w == CMD_WB) ? rq_data[gidx]
                  : any_sup           ? snp_data[sidx]
                  :                     mem_rdata;
    assign mem_we = act && ((cmd_w == CMD_WB) || (any_sup && snp_dirty[sidx]));

    mesi_flat_mem #(.AW(AW), .DW(DW), .SEED(MEM_SEED)) u_mem (
        .clk(clk), .rst(rst), .raddr(addr_w), .rdata(mem_rdata),
        .we(mem_we), .waddr(addr_w), .wdata(data_w)
    );

    for (genvar i = 0; i < N; i++) begin : g_line
        assign gnt[i] = act && (gidx == IW'(i));
        mesi_line_ctrl #(.N(N), .ID(i), .AW(AW), .DW(DW), .SETS(SETS), .IW(IW)) u_line (
            .clk(clk), .rst(rst),
            .cpu_valid(cpu_valid[i]), .cpu_write(cpu_write[i]),
            .cpu_addr(cpu_addr[i*AW +: AW]), .cpu_wdata(cpu_wdata[i*DW +: DW]),
            .cpu_ready(cpu_ready[i]), .cpu_rdata(cpu_rdata[i*DW +: DW]),
            .breq(breq[i]), .breq_cmd(rq_cmd[i]), .breq_addr(rq_addr[i]), .breq_data(rq_data[i]),
            .gnt(gnt[i]), .bus_active(act), .bus_cmd(cmd_w), .bus_addr(addr_w),
            .bus_src(gidx), .bus_data(data_w), .bus_shared(any_sup),
            .snp_hit(snp_hit[i]), .snp_dirty(snp_dirty[i]), .snp_data(snp_data[i]),
            .probe_addr(probe_addr), .probe_st(pst[i])
        );
        assign probe_state[2*i +: 2] = pst[i];
    end

    assign bus_active   = act;
    assign bus_cmd      = cmd_w;
    assign bus_src      = gidx;
    assign bus_addr     = addr_w;
    assign bus_shared   = any_sup;
    assign bus_c2c      = any_sup;
    assign bus_supplier = sidx;
    assign bus_data     = data_w;
endmodule

// File: rtl/mesi_cluster_chk.sv
module mesi_cluster_chk #(
    parameter int N  = 3,
    parameter int AW = 6,
    parameter int IW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   cpu_valid,
    input logic [N-1:0]   cpu_ready,
    input logic           bus_active,
    input logic [1:0]     bus_cmd,
    input logic [IW-1:0]  bus_src,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_shared,
    input logic           bus_c2c,
    input logic [IW-1:0]  bus_supplier,
    input logic [AW-1:0]  probe_addr,
    input logic [N*2-1:0] probe_state
);
    logic          fill_q, shared_q;
    logic [1:0]    cmd_q;
    logic [AW-1:0] addr_q;
    logic [IW-1:0] src_q;
    logic [1:0]    src_state;
    int            n_valid, n_mod;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= 1'b0; shared_q <= 1'b0; cmd_q <= '0; addr_q <= '0; src_q <= '0;
        end else begin
            fill_q <= bus_active; shared_q <= bus_shared; cmd_q <= bus_cmd;
            addr_q <= bus_addr;   src_q <= bus_src;
        end
    end

    assign src_state = probe_state[2*int'(src_q) +: 2];

    always_comb begin
        n_valid = 0;
        n_mod   = 0;
        for (int i = 0; i < N; i++) begin
            if (probe_state[2*i +: 2] != 2'd0) n_valid++;
            if (probe_state[2*i +: 2] == 2'd3) n_mod++;
        end
    end

    AST_SOLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (n_mod <= 1) && (n_mod == 0 || n_valid == 1)); // R9
    AST_FILL_EXCL: assert property (@(posedge clk) disable iff (rst)
        (fill_q && cmd_q == 2'd1 && !shared_q && probe_addr == addr_q) |-> src_state == 2'd2); // R1
    AST_FILL_SHARED: assert property (@(posedge clk) disable iff (rst)
        (fill_q && cmd_q == 2'd1 && shared_q && probe_addr == addr_q) |-> src_state == 2'd1); // R1
    AST_RDX_SOLE: assert property (@(posedge clk) disable iff (rst)
        (fill_q && cmd_q == 2'd2 && probe_addr == addr_q) |-> (src_state == 2'd3 && n_valid == 1)); // R3
    AST_WB_ALONE: assert property (@(posedge clk) disable iff (rst)
        (bus_active && bus_cmd == 2'd3) |-> (!bus_shared && !bus_c2c && !cpu_ready[bus_src])); // R7
    AST_SUPPLIER_OTHER: assert property (@(posedge clk) disable iff (rst)
        bus_c2c |-> (bus_active && bus_supplier != bus_src && bus_cmd != 2'd3)); // R6
    AST_READY_VALID: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready & ~cpu_valid) == '0); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> (!bus_c2c && !bus_shared && bus_cmd == 2'd0)); // R10
endmodule

bind mesi_cluster mesi_cluster_chk #(.N(N), .AW(AW), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .bus_active(bus_active), .bus_cmd(bus_cmd), .bus_src(bus_src), .bus_addr(bus_addr),
    .bus_shared(bus_shared), .bus_c2c(bus_c2c), .bus_supplier(bus_supplier),
    .probe_addr(probe_addr), .probe_state(probe_state)
);

// File: tb/tb_mesi_cluster.sv
module tb_mesi_cluster;
    localparam int N = 3, AW = 6, DW = 8;

    logic clk = 0, rst = 1;
    always #4 clk = ~clk;

    logic [N-1:0] cpu_valid = '0, cpu_write = '0, cpu_ready;
    logic [N*AW-1:0] cpu_addr = '0;
    logic [N*DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic bus_active, bus_shared, bus_c2c;
    logic [1:0] bus_cmd, bus_src, bus_supplier;
    logic [AW-1:0] bus_addr, probe_addr = 6'd5;
    logic [DW-1:0] bus_data;
    logic [N*2-1:0] probe_state;

    mesi_cluster dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, one step per clock
    int mst[N][4], mtag[N][4], mdat[N][4], mem[64];
    bit run_model = 0;

    always @(negedge clk) if (run_model) begin
        int idx[N], tg[N], need[N], vd[N], cmdv[N], snp[N];
        int g, bcmd, baddr, bidx, btg, sh, sup, sdirty, bdata, pidx, ptg;
        g = -1; sh = 0; sup = -1; bdata = 0; bcmd = 0; baddr = 0; bidx = -1; btg = 0; sdirty = 0;
        for (int c = 0; c < N; c++) begin
            int hit, own;
            idx[c] = cpu_addr[c*AW +: AW] % 4; tg[c] = cpu_addr[c*AW +: AW] / 4;
            hit = mst[c][idx[c]] != 0 && mtag[c][idx[c]] == tg[c];
            own = hit && mst[c][idx[c]] >= 2;
            need[c] = cpu_valid[c] && (cpu_write[c] ? !own : !hit);
            vd[c] = !hit && mst[c][idx[c]] == 3;
            cmdv[c] = vd[c] ? 3 : (cpu_write[c] ? 2 : 1);
            snp[c] = 0;
            if (need[c] && g < 0) g = c;
        end
        if (g >= 0) begin
            bcmd = cmdv[g];
            baddr = vd[g] ? mtag[g][idx[g]] * 4 + idx[g] : int'(cpu_addr[g*AW +: AW]);
            bidx = baddr % 4; btg = baddr / 4;
            for (int j = 0; j < N; j++)
                if (j != g && bcmd != 3 && mst[j][bidx] != 0 && mtag[j][bidx] == btg) begin
                    snp[j] = 1; sh = 1; if (sup < 0) sup = j;
                end
            bdata = (bcmd == 3) ? mdat[g][idx[g]] : (sup >= 0) ? mdat[sup][bidx] : mem[baddr];
            if (sup >= 0) sdirty = mst[sup][bidx] == 3;
        end
        check("R8", "bus_active", bus_active, g >= 0);
        if (g >= 0) begin
            check("R8", "bus_src", bus_src, g);
            check("R8", "bus_cmd", bus_cmd, bcmd);
            check("R7", "bus_addr", bus_addr, baddr);
            check("R1", "bus_shared", bus_shared, sh);
            check("R6", "bus_c2c", bus_c2c, sup >= 0);
            if (sup >= 0) check("R6", "bus_supplier", bus_supplier, sup);
            check("R5", "bus_data", bus_data, bdata);
        end
        pidx = probe_addr % 4; ptg = probe_addr / 4;
        for (int c = 0; c < N; c++) begin
            int erdy, ps;
            erdy = cpu_valid[c] && ((!need[c] && !(g >= 0 && g != c && bidx == idx[c]))
                                    || (c == g && bcmd != 3));
            check("R4", "cpu_ready", cpu_ready[c], erdy);
            if (erdy && !cpu_write[c])
                check("R5", "cpu_rdata", cpu_rdata[c*DW +: DW],
                      (c == g) ? bdata : mdat[c][idx[c]]);
            ps = (mst[c][pidx] != 0 && mtag[c][pidx] == ptg) ? mst[c][pidx] : 0;
            check("R9", "probe_state", probe_state[2*c +: 2], ps);
            if (erdy && cpu_write[c] && c != g) begin
                mst[c][idx[c]] = 3; mdat[c][idx[c]] = cpu_wdata[c*DW +: DW];
            end
        end
        for (int j = 0; j < N; j++) if (snp[j]) mst[j][bidx] = (bcmd == 1) ? 1 : 0;
        if (g >= 0) begin
            if (bcmd == 3 || sdirty) mem[baddr] = bdata;
            case (bcmd)
                3: mst[g][idx[g]] = 0;
                1: begin mst[g][idx[g]] = sh ? 1 : 2; mtag[g][idx[g]] = tg[g]; mdat[g][idx[g]] = bdata; end
                2: begin mst[g][idx[g]] = 3; mtag[g][idx[g]] = tg[g]; mdat[g][idx[g]] = cpu_wdata[g*DW +: DW]; end
                default: ;
            endcase
        end
    end

    // Transaction capture per request
    int t_act[N], t_cmd[N], t_c2c[N], t_sup[N], t_rd[N], t_wb[N];
    longint t_done[N];

    task automatic issue(int c, bit w, int a, int d);
        @(posedge clk); #1;
        cpu_valid[c] = 1; cpu_write[c] = w;
        cpu_addr[c*AW +: AW] = AW'(a); cpu_wdata[c*DW +: DW] = DW'(d);
        t_wb[c] = 0;
        forever begin
            @(negedge clk);
            if (bus_active && bus_cmd == 2'd3 && bus_src == c) t_wb[c] = 1;
            if (cpu_ready[c]) begin
                t_act[c] = bus_active && bus_src == c; t_cmd[c] = bus_cmd;
                t_c2c[c] = bus_c2c; t_sup[c] = bus_supplier;
                t_rd[c] = cpu_rdata[c*DW +: DW]; t_done[c] = $time;
                break;
            end
        end
        @(posedge clk); #1;
        cpu_valid[c] = 0;
    endtask

    task automatic states(string req, int s0, int s1, int s2);
        check(req, "state c0", probe_state[1:0], s0);
        check(req, "state c1", probe_state[3:2], s1);
        check(req, "state c2", probe_state[5:4], s2);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < N; c++) for (int s = 0; s < 4; s++) begin
            mst[c][s] = 0; mtag[c][s] = 0; mdat[c][s] = 0;
        end
        for (int a = 0; a < 64; a++) mem[a] = a ^ 'h5A;
        repeat (3) @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        states("R10", 0, 0, 0);
        check("R10", "bus idle", bus_active, 0);
        check("R10", "bus_cmd idle", bus_cmd, 0);
        run_model = 1;

        issue(0, 0, 5, 0);                     // P1 read
        check("R1", "read miss cmd", t_cmd[0], 1);
        check("R6", "memory supplies", t_c2c[0], 0);
        check("R10", "memory pattern", t_rd[0], 'h5F);
        states("R1", 2, 0, 0);
        issue(0, 1, 5, 'h11);                  // P1 write
        check("R2", "silent write", t_act[0], 0);
        states("R2", 3, 0, 0);
        issue(2, 0, 5, 0);                     // P3 read
        check("R5", "flush from owner", t_c2c[2], 1);
        check("R5", "flusher id", t_sup[2], 0);
        check("R5", "flushed data", t_rd[2], 'h11);
        states("R5", 1, 0, 1);
        issue(2, 1, 5, 'h22);                  // P3 write
        check("R3", "ownership cmd", t_cmd[2], 2);
        states("R3", 0, 0, 3);
        issue(0, 0, 5, 0);                     // P1 read
        check("R5", "flusher id", t_sup[0], 2);
        check("R5", "flushed data", t_rd[0], 'h22);
        states("R5", 1, 0, 1);
        issue(2, 0, 5, 0);                     // P3 read hit
        check("R4", "hit no bus", t_act[2], 0);
        check("R4", "hit data", t_rd[2], 'h22);
        states("R4", 1, 0, 1);
        issue(1, 0, 5, 0);                     // P2 read
        check("R6", "lowest sharer", t_sup[1], 0);
        check("R6", "c2c", t_c2c[1], 1);
        states("R6", 1, 1, 1);

        issue(1, 1, 5, 'h33);                  // write in Shared
        check("R3", "shared write cmd", t_cmd[1], 2);
        states("R3", 0, 3, 0);
        issue(1, 0, 9, 0);                     // dirty eviction
        check("R7", "writeback seen", t_wb[1], 1);
        check("R7", "fill data", t_rd[1], 'h53);
        states("R7", 0, 0, 0);
        issue(0, 0, 5, 0);                     // memory got the write-back
        check("R7", "memory supplies", t_c2c[0], 0);
        check("R7", "written back data", t_rd[0], 'h33);
        issue(0, 0, 9, 0);                     // clean eviction
        check("R7", "no writeback", t_wb[0], 0);
        check("R6", "supplier", t_sup[0], 1);
        check("R7", "data", t_rd[0], 'h53);
        probe_addr = 6'd9;
        #1 states("R5", 1, 1, 0);
        issue(0, 1, 9, 'h66);
        check("R3", "shared write cmd", t_cmd[0], 2);
        states("R3", 3, 0, 0);

        probe_addr = 6'd2;
        fork
            issue(1, 1, 2, 'h44);
            issue(2, 1, 2, 'h55);
        join
        check("R8", "lowest index first", t_done[1] < t_done[2], 1);
        states("R8", 0, 0, 3);
        issue(0, 0, 2, 0);
        check("R8", "final data", t_rd[0], 'h55);
        states("R5", 1, 0, 1);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule